// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on a single line that rests high. A character written over the bus goes into a holding buffer first. From there it moves into a frame shifter, which sends it out. The buffer can take the next character while the current one is still on the line, so software can keep the line busy without gaps. Timing comes from a strobe at sixteen times the bit rate. The divider that makes this strobe sits outside the block, and so does the bus address decoding.

Each frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Two status flags report progress. One says the holding buffer can take a new character. The other says the line has gone idle with nothing left to send. A one-cycle interrupt pulse follows whichever of the two flags the configuration picks.

Top module: `uart_dbuf_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, `txd`=1, `buf_empty`=1, `shift_done`=1 and `tx_irq`=0.
- R2: A cycle with `wr_en`=1 makes `buf_empty` read 0 in the next cycle. `buf_empty` returns to 1 in the same cycle that the held character moves into the shifter, which is the cycle its start bit appears on `txd`.
- R3: A frame is one 0 start bit, then the data bits least significant first, then the optional parity bit, then the stop bits at 1. `cfg_len8`=1 sends 8 data bits and 0 sends bits 6..0. `cfg_stop2`=1 sends two stop bits and 0 sends one. Each bit lasts 16 `tick16` strobes.
- R4: With `cfg_par_en`=1 a parity bit follows the data. `cfg_par_odd`=0 makes the count of ones over the sent data bits plus parity even, and 1 makes it odd. Data bit 7 is left out of the count in 7-bit mode.
- R5: A write to an idle line starts the frame on a bit boundary 8 to 24 ticks (half a bit to one and a half bits) after the write.
- R6: If the buffer holds a character when the last stop bit ends, that character's start bit follows with no idle gap, and `shift_done` stays 0.
- R7: `shift_done` rises when the last stop bit ends (the second one in 2-stop mode) and the buffer is empty. It falls when a start bit begins.
- R8: `tx_irq` is a one-cycle pulse. It fires when `buf_empty` rises if `cfg_irq_sel`=0, and when `shift_done` rises if `cfg_irq_sel`=1.
- R9: A second write before the held character has been taken replaces it, and only the later character is sent.
- R10: While `shift_done`=1, `txd` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to send |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_irq_sel | input | 1 | Interrupt source: 0 buffer empty, 1 shift complete |
| txd | output | 1 | Serial output, high at rest |
| buf_empty | output | 1 | Holding buffer can accept a character |
| shift_done | output | 1 | Line idle and nothing pending |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
The transmitter is driven with several formats: 8 data bits with no parity and one stop bit, 7 data bits with even parity and two stop bits, and 8 data bits with odd parity. Comparing these shows whether the frame length, the parity rule and the stop-bit count are handled correctly, and whether bit 7 is dropped in 7-bit mode. A back-to-back pair with the buffer-empty interrupt is compared against a single frame with the shift-complete interrupt. This tells apart a reload at the frame boundary from an idle restart, and shows which flag drives the pulse. An overwrite before the hand-off, together with the measured write-to-start latency, checks the buffer's replace rule and the mid-bit arming.

// File: rtl/uart_tx_pkg.sv
// Shared constants, configuration type and frame builder for the serial
// transmitter. Assumes the tick strobe runs at TICKS_PER_BIT times the bit rate.
package uart_tx_pkg;
    localparam int TICKS_PER_BIT = 16;
    localparam int TICK_CNT_W    = $clog2(TICKS_PER_BIT);
    localparam int MAX_DATA      = 8;
    localparam int MAX_FRAME     = 1 + MAX_DATA + 1 + 2;
    localparam int FRAME_CNT_W   = $clog2(MAX_FRAME + 1);

    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } tx_cfg_t;

    // Number of data bits sent for a configuration.
    function automatic int data_bits(input tx_cfg_t c);
        return c.len8 ? MAX_DATA : MAX_DATA - 1;
    endfunction

    // Total bits on the line for one frame.
    function automatic logic [FRAME_CNT_W-1:0] frame_len(input tx_cfg_t c);
        int n;
        n = 1 + data_bits(c) + (c.par_en ? 1 : 0) + (c.stop2 ? 2 : 1);
        return FRAME_CNT_W'(n);
    endfunction

    // Frame image, bit 0 goes out first; unused upper bits are stop-level ones.
    function automatic logic [MAX_FRAME-1:0] build_frame(input logic [MAX_DATA-1:0] d,
                                                         input tx_cfg_t c);
        logic [MAX_FRAME-1:0] f;
        logic                 p;
        int                   nd;
        nd = data_bits(c);
        f  = '1;
        f[0] = 1'b0;
        p  = c.par_odd;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < nd) begin
                f[i+1] = d[i];
                p      = p ^ d[i];
            end
        end
        for (int i = MAX_DATA - 1; i <= MAX_DATA; i++) begin
            if (i == nd && c.par_en) begin
                f[i+1] = p;
            end
        end
        return f;
    endfunction
endpackage

// File: rtl/tx_bit_clock.sv
// Bit-phase counter. Counts tick strobes and flags the middle and the last tick
// of each bit period. Assumes tick is a one-cycle strobe.
module tx_bit_clock #(
    parameter int TICKS = uart_tx_pkg::TICKS_PER_BIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic mid_stb,
    output logic edge_stb
);
    localparam int CW = $clog2(TICKS);
    localparam logic [CW-1:0] MID_CNT  = CW'(TICKS / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(TICKS - 1);

    logic [CW-1:0] phase;

    // Advance the phase on every tick; wrap after the last tick of a bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == LAST_CNT) ? '0 : phase + 1'b1;
        end
    end

    assign mid_stb  = tick && (phase == MID_CNT);
    assign edge_stb = tick && (phase == LAST_CNT);
endmodule

// File: rtl/tx_hold_reg.sv
// Holding buffer in front of the shifter. A write fills it (a later write
// replaces a pending one); a take from the shifter empties it. A write in the
// same cycle as a take keeps the new data pending.
module tx_hold_reg #(
    parameter int W = uart_tx_pkg::MAX_DATA
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic [W-1:0] data,
    output logic         empty,
    output logic         empty_nxt
);
    // Next empty state: a write wins over a take.
    always_comb begin
        if (wr_en)     empty_nxt = 1'b0;
        else if (take) empty_nxt = 1'b1;
        else           empty_nxt = empty;
    end

    // Hold the character and the empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            empty <= 1'b1;
        end else begin
            empty <= empty_nxt;
            if (wr_en) data <= wr_data;
        end
    end
endmodule

// File: rtl/tx_frame_shifter.sv
// Frame shifter. On an idle line a pending character arms at a mid-bit point
// and loads at the following bit boundary. During a frame a pending character
// loads right at the end of the last stop bit. Drives txd and the done flag.
module tx_frame_shifter #(
    parameter int W       = uart_tx_pkg::MAX_DATA,
    parameter int FRAME   = uart_tx_pkg::MAX_FRAME,
    parameter int FCNT_W  = uart_tx_pkg::FRAME_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mid_stb,
    input  logic                 edge_stb,
    input  logic                 hold_full,
    input  logic [W-1:0]         hold_data,
    input  uart_tx_pkg::tx_cfg_t cfg,
    output logic                 take,
    output logic                 txd,
    output logic                 done,
    output logic                 done_nxt
);
    logic              busy;
    logic              armed;
    logic [FRAME-1:0]  frame;
    logic [FCNT_W-1:0] left;
    logic              last_bit;

    assign last_bit = busy && (left == FCNT_W'(1));
    assign take     = edge_stb && hold_full && (busy ? last_bit : armed);
    assign txd      = busy ? frame[0] : 1'b1;

    // Next done state: cleared by a load, set when the last stop bit ends.
    always_comb begin
        if (take)                      done_nxt = 1'b0;
        else if (edge_stb && last_bit) done_nxt = 1'b1;
        else                           done_nxt = done;
    end

    // Arm an idle-line start at mid-bit so the start bit lands 0.5 to 1.5 bits later.
    always_ff @(posedge clk) begin
        if (!rst_n)                              armed <= 1'b0;
        else if (take)                           armed <= 1'b0;
        else if (mid_stb && !busy && hold_full)  armed <= 1'b1;
    end

    // Load, shift and retire frames on bit boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            frame <= '1;
            left  <= '0;
            done  <= 1'b1;
        end else begin
            done <= done_nxt;
            if (take) begin
                busy  <= 1'b1;
                frame <= uart_tx_pkg::build_frame(hold_data, cfg);
                left  <= uart_tx_pkg::frame_len(cfg);
            end else if (edge_stb && busy) begin
                frame <= {1'b1, frame[FRAME-1:1]};
                left  <= left - 1'b1;
                if (last_bit) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_dbuf_tx.sv
// Double-buffered asynchronous serial transmitter top. Connects the bit-phase
// counter, the holding buffer and the frame shifter, and makes the interrupt
// pulse on the rising edge of the selected status flag.
module uart_dbuf_tx #(
    parameter int DATA_W = uart_tx_pkg::MAX_DATA,
    parameter int TICKS  = uart_tx_pkg::TICKS_PER_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_len8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic              cfg_irq_sel,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_done,
    output logic              tx_irq
);
    uart_tx_pkg::tx_cfg_t cfg;
    logic              mid_stb, edge_stb, take;
    logic              empty_nxt, done_nxt;
    logic [DATA_W-1:0] hold_data;

    assign cfg = '{len8: cfg_len8, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};

    tx_bit_clock #(.TICKS(TICKS)) u_clk (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .mid_stb(mid_stb), .edge_stb(edge_stb)
    );

    tx_hold_reg #(.W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .take(take), .data(hold_data), .empty(buf_empty), .empty_nxt(empty_nxt)
    );

    tx_frame_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .mid_stb(mid_stb), .edge_stb(edge_stb),
        .hold_full(!buf_empty), .hold_data(hold_data), .cfg(cfg),
        .take(take), .txd(txd), .done(shift_done), .done_nxt(done_nxt)
    );

    // Pulse the interrupt in the cycle the selected flag rises.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_irq <= 1'b0;
        else        tx_irq <= cfg_irq_sel ? (done_nxt && !shift_done)
                                          : (empty_nxt && !buf_empty);
    end
endmodule

// File: rtl/uart_dbuf_tx_chk.sv
// Property checker for the transmitter, attached by bind below.
module uart_dbuf_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic cfg_irq_sel,
    input logic txd,
    input logic buf_empty,
    input logic shift_done,
    input logic tx_irq
);
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !buf_empty); // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(shift_done) |-> !txd); // R7
    AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) $fell(shift_done) |-> $past(!buf_empty)); // R2
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) tx_irq |-> ($past(cfg_irq_sel) ? $rose(shift_done) : $rose(buf_empty))); // R8
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tx_irq |=> !tx_irq); // R8
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) shift_done |-> txd); // R10
endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_irq_sel(cfg_irq_sel),
    .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .tx_irq(tx_irq)
);

// File: tb/uart_dbuf_tx_test.sv
// Directed bench: one task per scenario; ticks every 4 clocks, so a bit is 64 clocks.
module uart_dbuf_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0, cfg_irq_sel = 1'b0;
    logic       txd, buf_empty, shift_done, tx_irq;
    int         total = 0, bad = 0;
    int         tick_cnt = 0, irq_cnt = 0;

    uart_dbuf_tx uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_irq_sel(cfg_irq_sel),
        .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .tx_irq(tx_irq)
    );

    always #4 clk = ~clk;

    // Tick strobe generator, one clock high every four.
    initial begin
        @(negedge clk);
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            tick_cnt++;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    // Interrupt pulse counter.
    always @(negedge clk) if (rst_n && tx_irq) irq_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected line bits, first bit in position 0.
    function automatic int exp_frame(input logic [7:0] d, input bit l8, pe, po, s2,
                                     output logic [11:0] v);
        int n = 0;
        bit ones = po;
        v = '1;
        v[n++] = 1'b0;
        for (int i = 0; i < (l8 ? 8 : 7); i++) begin
            v[n++] = d[i];
            ones ^= d[i];
        end
        if (pe) v[n++] = ones;
        n += s2 ? 2 : 1;
        return n;
    endfunction

    task automatic write(input logic [7:0] d);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Wait for a start bit; return latency in ticks from t0.
    task automatic wait_start(input int t0, output int lat);
        int n = 0;
        while (txd !== 1'b0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        lat = tick_cnt - t0;
        check(txd === 1'b0, "R5 start seen", txd, 0);
    endtask

    // Entered at a start-bit edge (+0); compares every bit at its middle.
    task automatic check_frame(input logic [7:0] d, input bit l8, pe, po, s2,
                               input string req, input bit last);
        logic [11:0] v, got;
        int n;
        bit done_ok = 1'b1;
        n = exp_frame(d, l8, pe, po, s2, v);
        got = '1;
        repeat (32) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            got[k] = txd;
            if (shift_done !== 1'b0) done_ok = 1'b0;
            if (k < n - 1) repeat (64) @(negedge clk);
        end
        check(got == v, req, got, v);
        check(done_ok, "R7 shift_done low during frame", 1, 0);
        if (last) begin
            repeat (34) @(negedge clk);
            check(shift_done === 1'b1 && txd === 1'b1, "R7 done after last stop",
                  {shift_done, txd}, 3);
        end else begin
            repeat (32) @(negedge clk);
        end
    endtask

    task automatic set_cfg(input bit l8, pe, po, s2, sel);
        cfg_len8 = l8; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2; cfg_irq_sel = sel;
    endtask

    task automatic t_reset;
        check(txd === 1'b1 && buf_empty === 1'b1 && shift_done === 1'b1 && tx_irq === 1'b0,
              "R1 reset state", {txd, buf_empty, shift_done, tx_irq}, 4'b1110);
    endtask

    task automatic t_single_8n1;
        int t0, lat;
        set_cfg(1, 0, 0, 0, 1);
        irq_cnt = 0;
        t0 = tick_cnt;
        write(8'hA5);
        check(buf_empty === 1'b0, "R2 write fills buffer", buf_empty, 0);
        wait_start(t0, lat);
        check(lat >= 8 && lat <= 25, "R5 start latency", lat, 16);
        check(buf_empty === 1'b1, "R2 empty at start bit", buf_empty, 1);
        check_frame(8'hA5, 1, 0, 0, 0, "R3 8N1 frame", 1);
        check(irq_cnt == 1, "R8 irq on shift complete", irq_cnt, 1);
        repeat (100) @(negedge clk);
        check(txd === 1'b1 && shift_done === 1'b1, "R10 idle high", txd, 1);
    endtask

    task automatic t_7e2;
        int t0, lat;
        set_cfg(0, 1, 0, 1, 1);
        t0 = tick_cnt;
        write(8'hD3);
        wait_start(t0, lat);
        check(lat >= 8 && lat <= 25, "R5 start latency 7E2", lat, 16);
        check_frame(8'hD3, 0, 1, 0, 1, "R3 R4 7E2 frame bit7 dropped", 1);
    endtask

    task automatic t_8o1;
        int t0, lat;
        set_cfg(1, 1, 1, 0, 1);
        t0 = tick_cnt;
        write(8'h37);
        wait_start(t0, lat);
        check_frame(8'h37, 1, 1, 1, 0, "R4 8O1 odd parity", 1);
    endtask

    task automatic t_back_to_back;
        int t0, lat;
        set_cfg(1, 0, 0, 1, 0);
        irq_cnt = 0;
        t0 = tick_cnt;
        write(8'h5C);
        wait_start(t0, lat);
        write(8'hE1);
        check(buf_empty === 1'b0, "R6 second char pending", buf_empty, 0);
        check_frame(8'h5C, 1, 0, 0, 1, "R6 first of pair", 0);
        check_frame(8'hE1, 1, 0, 0, 1, "R6 second follows without gap", 1);
        check(irq_cnt == 2, "R8 irq on buffer empty", irq_cnt, 2);
    endtask

    task automatic t_overwrite;
        int t0, lat;
        set_cfg(1, 0, 0, 0, 0);
        t0 = tick_cnt;
        write(8'h11);
        write(8'h3C);
        wait_start(t0, lat);
        check_frame(8'h3C, 1, 0, 0, 0, "R9 later write replaces pending", 1);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        repeat (20) @(negedge clk);
        t_single_8n1();
        t_7e2();
        t_8o1();
        t_back_to_back();
        t_overwrite();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule